// File: doc/BRIEF.md
# Multicart Outer-Bank PRG Address Composer

This block sits beside an inner bank controller in a multi-game cartridge mapper. It keeps four 8-bit outer-bank registers, written from the CPU bus. It merges the register contents with the inner controller's 8 KiB PRG bank number to form the final PRG bank number.

Each bank bit has its own source. A per-bit mask, built from several register bits, picks either the outer base or the inner controller's bank bit for that position.

Register 3 selects one of two modes:

- **Inner-controller mode.** The low bank bits pass straight through from the inner controller.
- **Fixed-window mode.** The low bank nibble is replaced by register bits and the CPU address lines A14 and A13. This gives a fixed 16 KiB or 32 KiB window.

A lockout bit freezes the registers, but only while the inner-controller mode is selected. A further register bit asserts an extra PRG RAM enable for the 0x5000–0x5FFF window. The bank output is combinational from the registers and inputs.

Top module: `mc_prg_compose`

## Requirements
- R1: A write with `reg_wr` high at a clock edge stores `cpu_data` into register number `cpu_addr[1:0]`. The effect appears on the outputs after that edge.
- R2: While register 3 bit 7 is 1 and register 3 bit 4 is 0, every write is ignored, including writes to register 3.
- R3: With register 3 bits 7 and 4 both 1, writes still take effect.
- R4: Reset clears all four registers. After reset, `prg_bank` equals `inner_bank` with bits 7..6 forced to 0, and `ram_5xxx_en` is 0.
- R5: In inner-controller mode (register 3 bit 4 = 0), the bank is formed as follows:
  - For each bit, a mask bit of 1 takes `inner_bank`, and a mask bit of 0 takes the base nibble shifted up by four.
  - The mask is: bit7 = reg1 bit5, bit6 = reg1 bit6, bit5 = NOT reg1 bit7, bit4 = NOT reg0 bit6, bits 3..0 = 1.
  - The base nibble, from bank bit 7 down to bank bit 4, is reg1 bit4, reg0 bit2, reg0 bit1, reg0 bit0.
- R6: In fixed-window mode (register 3 bit 4 = 1), bank bits 7..4 follow the R5 rule, and bank bit 0 equals CPU A13.
- R7: In fixed-window mode with reg1 bit1 = 1 (32 KiB), bank bits 3..2 equal reg3 bits 3..2, and bank bit 1 equals CPU A14.
- R8: In fixed-window mode with reg1 bit1 = 0 (16 KiB), bank bits 3..1 equal reg3 bits 3..1.
- R9: `ram_5xxx_en` equals register 3 bit 5.
- R10: A change of `inner_bank` or of the CPU address reaches `prg_bank` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Qualified write strobe to the outer registers |
| cpu_addr | input | 16 | CPU address; bits 1..0 pick the register, bits 14 and 13 feed fixed-window mode |
| cpu_data | input | 8 | CPU write data |
| inner_bank | input | 8 | 8 KiB PRG bank number from the inner controller |
| prg_bank | output | 8 | Final 8 KiB PRG bank number |
| ram_5xxx_en | output | 1 | Extra PRG RAM enable for 0x5000–0x5FFF |

## Verification
Register writes are the only clocked path. A write strobed at one rising edge shows on `prg_bank` and `ram_5xxx_en` from that edge on. The bench drives every write on a falling edge and removes the strobe on the next falling edge. It checks one nanosecond later, so exactly one edge has passed.

Changes to `inner_bank` and to the CPU address settle with no edge at all. Those checks sample one nanosecond after the inputs change, while the clock is still low, so any registered stage in that path would show up as a stale value.

// File: rtl/mc_prg_pkg.sv
package mc_prg_pkg;
   localparam int unsigned REG_W     = 8;
   localparam int unsigned REG_COUNT = 4;
   localparam int unsigned SEL_W     = $clog2(REG_COUNT);
   localparam int unsigned NIB_W     = 4;
   localparam int unsigned MAX_BANK  = 12;

   typedef logic [REG_W-1:0] reg_t;

   typedef struct packed {
      logic [REG_W-1:0] mask;      // 1: bit from inner controller
      logic [REG_W-1:0] base;      // outer base, shifted up by a nibble
      logic             fixed_win; // fixed 16/32 KiB window mode
      logic             wide_win;  // 32 KiB window
      logic [3:1]       win_bits;  // register-supplied window bits
      logic             ram_en;
   } bank_ctl_t;
endpackage

// File: rtl/mc_outer_regs.sv
module mc_outer_regs
   import mc_prg_pkg::*;
#(
   parameter int unsigned DATA_W = REG_W,
   parameter int unsigned NREGS  = REG_COUNT
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [$clog2(NREGS)-1:0]      wr_sel,
   input  logic [DATA_W-1:0]             wr_data,
   output logic [NREGS-1:0][DATA_W-1:0]  regs_q
);
   localparam int unsigned CTL_IDX = NREGS - 1;

   if (DATA_W != 8) begin : g_bad_w
      $error("mc_outer_regs: DATA_W must be 8");
   end
   if (NREGS != 4) begin : g_bad_n
      $error("mc_outer_regs: NREGS must be 4");
   end

   logic locked;
   assign locked = regs_q[CTL_IDX][7] & ~regs_q[CTL_IDX][4];

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs_q[g] <= '0;
         else if (wr_en && !locked && (wr_sel == g))
            regs_q[g] <= wr_data;
      end
   end

   // R1: an accepted write lands in the addressed register
   a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !locked) |=> regs_q[$past(wr_sel)] == $past(wr_data));

   // R2: a locked write leaves every register untouched
   a_r2_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && locked) |=> $stable(regs_q));

   // R4: leaving reset, all registers are clear
   a_r4_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (regs_q == '0));
endmodule

// File: rtl/mc_field_decode.sv
module mc_field_decode
   import mc_prg_pkg::*;
(
   input  reg_t      r0,
   input  reg_t      r1,
   input  reg_t      r3,
   output bank_ctl_t ctl
);
   logic [REG_W-1:0] mask_raw;
   logic [REG_W-1:0] base_raw;

   always_comb begin
      mask_raw    = 8'h3F | {r1[5], r1[6], 6'b0};
      mask_raw[4] = mask_raw[4] ^ r0[6];
      mask_raw[5] = mask_raw[5] ^ r1[7];

      base_raw    = {r0[5:4], r1[3:2], r1[4], r0[2:0]};

      ctl.mask      = mask_raw;
      ctl.base      = base_raw;
      ctl.fixed_win = r3[4];
      ctl.wide_win  = r1[1];
      ctl.win_bits  = r3[3:1];
      ctl.ram_en    = r3[5];
   end

   logic unused_bits;
   assign unused_bits = ^{r1[0], r3[7:6], r3[0], r0[7], r0[3]};
endmodule

// File: rtl/mc_bank_select.sv
module mc_bank_select
   import mc_prg_pkg::*;
#(
   parameter int unsigned BANK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bank_ctl_t         ctl,
   input  logic [REG_W-1:0]  inner_bank,
   input  logic              cpu_a14,
   input  logic              cpu_a13,
   output logic [BANK_W-1:0] bank
);
   if (BANK_W < REG_W || BANK_W > MAX_BANK) begin : g_bad_w
      $error("mc_bank_select: BANK_W out of range 8..12");
   end

   logic [MAX_BANK-1:0] base_w;
   logic [MAX_BANK-1:0] full;
   logic [REG_W-1:0]    mask_eff;
   logic [NIB_W-1:0]    win_low;

   assign base_w   = {ctl.base, {NIB_W{1'b0}}};
   assign mask_eff = ctl.fixed_win ? (ctl.mask & 8'hF0) : ctl.mask;
   assign win_low  = ctl.wide_win ? {ctl.win_bits[3:2], cpu_a14, cpu_a13}
                                  : {ctl.win_bits, cpu_a13};

   for (genvar i = 0; i < MAX_BANK; i++) begin : g_bit
      if (i < NIB_W) begin : g_low
         assign full[i] = ctl.fixed_win ? win_low[i] : inner_bank[i];
      end else if (i < REG_W) begin : g_mid
         assign full[i] = mask_eff[i] ? inner_bank[i] : base_w[i];
      end else begin : g_high
         assign full[i] = base_w[i];
      end
   end

   assign bank = full[BANK_W-1:0];

   if (BANK_W < MAX_BANK) begin : g_sink
      logic unused_high;
      assign unused_high = ^full[MAX_BANK-1:BANK_W];
   end

   // R5: inner mode passes the low nibble through
   a_r5_inner_low: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.fixed_win |-> (bank[3:0] == inner_bank[3:0]));

   // R6: window mode drives bit 0 from A13
   a_r6_a13_bit0: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.fixed_win |-> (bank[0] == cpu_a13));

   // R7: 32 KiB window drives bit 1 from A14
   a_r7_a14_bit1: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.fixed_win && ctl.wide_win) |-> (bank[1] == cpu_a14));

   // R8: 16 KiB window takes bits 3..1 from the register
   a_r8_narrow_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.fixed_win && !ctl.wide_win) |-> (bank[3:1] == ctl.win_bits));
endmodule

// File: rtl/mc_prg_compose.sv
module mc_prg_compose
   import mc_prg_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned BANK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [REG_W-1:0]  cpu_data,
   input  logic [REG_W-1:0]  inner_bank,
   output logic [BANK_W-1:0] prg_bank,
   output logic              ram_5xxx_en
);
   localparam int unsigned A14 = 14;
   localparam int unsigned A13 = 13;

   if (ADDR_W < 15) begin : g_bad_a
      $error("mc_prg_compose: ADDR_W must cover A14");
   end

   logic [REG_COUNT-1:0][REG_W-1:0] regs;
   bank_ctl_t                       ctl;

   mc_outer_regs #(.DATA_W(REG_W), .NREGS(REG_COUNT)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .wr_sel  (cpu_addr[SEL_W-1:0]),
      .wr_data (cpu_data),
      .regs_q  (regs)
   );

   mc_field_decode u_dec (
      .r0  (regs[0]),
      .r1  (regs[1]),
      .r3  (regs[3]),
      .ctl (ctl)
   );

   mc_bank_select #(.BANK_W(BANK_W)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl        (ctl),
      .inner_bank (inner_bank),
      .cpu_a14    (cpu_addr[A14]),
      .cpu_a13    (cpu_addr[A13]),
      .bank       (prg_bank)
   );

   assign ram_5xxx_en = ctl.ram_en;

   logic unused_in;
   assign unused_in = ^{regs[2], cpu_addr[ADDR_W-1:A14+1], cpu_addr[A13-1:SEL_W]};

   // R9: RAM enable tracks the register bit written one edge earlier
   a_r9_ram_en: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && cpu_addr[1:0] == 2'd3 && !(regs[3][7] && !regs[3][4]))
      |=> (ram_5xxx_en == $past(cpu_data[5])));
endmodule

// File: tb/mc_prg_compose_test.sv
module mc_prg_compose_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic [7:0]  inner_bank = '0;
   logic [7:0]  prg_bank;
   logic        ram_5xxx_en;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] m [4];

   always #10 clk = ~clk;

   mc_prg_compose uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .cpu_addr(cpu_addr),
      .cpu_data(cpu_data), .inner_bank(inner_bank),
      .prg_bank(prg_bank), .ram_5xxx_en(ram_5xxx_en)
   );

   function automatic logic [7:0] exp_bank(input logic [7:0] r0, r1, r3, inr,
                                           input logic a14, a13);
      logic [7:0] mk;
      logic [7:0] low;
      mk  = {r1[5], r1[6], ~r1[7], ~r0[6], 4'hF};
      low = 8'h00;
      if (r3[4]) begin
         mk  = mk & 8'hF0;
         low = r1[1] ? {4'h0, r3[3:2], a14, a13} : {4'h0, r3[3:1], a13};
      end
      return ({r1[4], r0[2:0], 4'h0} & ~mk) | (inr & mk) | low;
   endfunction

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic check_bank(input string req);
      check(req, prg_bank, exp_bank(m[0], m[1], m[3], inner_bank,
                                    cpu_addr[14], cpu_addr[13]));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      reg_wr = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 4; k++) m[k] = 8'h00;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1;
      cpu_addr = {$urandom_range(0, 16383), sel} & 16'h9FFF;
      cpu_data = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (!(m[3][7] && !m[3][4])) m[sel] = d;
      #1;
   endtask

   task automatic set_in(input logic [7:0] inr, input logic a14, input logic a13);
      inner_bank = inr;
      cpu_addr[14] = a14;
      cpu_addr[13] = a13;
      #1;
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      do_reset();

      // R4: reset state
      set_in(8'hA5, 1'b0, 1'b0);
      check("R4", prg_bank, 8'h25);
      check("R4", {7'd0, ram_5xxx_en}, 8'h00);

      // R1: write register 0 base bit -> bank bit 6
      wr(2'd0, 8'h04);
      set_in(8'h00, 1'b0, 1'b0);
      check("R1", prg_bank, 8'h40);
      wr(2'd2, 8'hFF);
      check("R1", prg_bank, 8'h40);

      // R5: mask from r1 bits 5,6 and r0 bit 6
      wr(2'd1, 8'h60);
      set_in(8'hFF, 1'b0, 1'b0);
      check("R5", prg_bank, 8'hFF);
      wr(2'd1, 8'h90);
      set_in(8'h0F, 1'b0, 1'b0);
      check_bank("R5");

      // R9: RAM enable bit
      wr(2'd3, 8'h20);
      check("R9", {7'd0, ram_5xxx_en}, 8'h01);

      // R7: 32 KiB window
      wr(2'd1, 8'h02);
      wr(2'd3, 8'h1C);
      set_in(8'h00, 1'b1, 1'b0);
      check("R7", prg_bank & 8'h0F, 8'h0E);
      set_in(8'h00, 1'b0, 1'b1);
      check("R7", prg_bank & 8'h0F, 8'h0D);

      // R8: 16 KiB window
      wr(2'd1, 8'h00);
      wr(2'd3, 8'h1A);
      set_in(8'hFF, 1'b1, 1'b0);
      check("R8", prg_bank & 8'h0F, 8'h0A);

      // R6: window mode high nibble and A13
      set_in(8'hC3, 1'b0, 1'b1);
      check_bank("R6");

      // R10: combinational path, no edge
      wr(2'd3, 8'h00);
      @(negedge clk);
      set_in(8'h3C, 1'b0, 1'b0);
      check("R10", prg_bank, exp_bank(m[0], m[1], m[3], 8'h3C, 1'b0, 1'b0));
      set_in(8'h11, 1'b0, 1'b0);
      check("R10", prg_bank, exp_bank(m[0], m[1], m[3], 8'h11, 1'b0, 1'b0));

      // R2: lockout in inner mode
      do_reset();
      wr(2'd3, 8'h80);
      wr(2'd0, 8'h04);
      set_in(8'h00, 1'b0, 1'b0);
      check("R2", prg_bank, 8'h00);
      wr(2'd3, 8'h20);
      check("R2", {7'd0, ram_5xxx_en}, 8'h00);

      // R3: lock bit has no effect in window mode
      do_reset();
      wr(2'd3, 8'h90);
      wr(2'd0, 8'h04);
      set_in(8'h00, 1'b0, 1'b1);
      check("R3", prg_bank, 8'h41);

      // random phase: R5..R8 by mode
      do_reset();
      for (int it = 0; it < 600; it++) begin
         logic [1:0] sel;
         logic [7:0] d;
         if (it % 64 == 63) do_reset();
         sel = 2'($urandom_range(0, 3));
         d   = 8'($urandom);
         if (sel == 2'd3 && ($urandom_range(0, 7) != 0)) d[7] = 1'b0;
         wr(sel, d);
         set_in(8'($urandom), 1'($urandom), 1'($urandom));
         if (m[3][4]) check_bank(m[1][1] ? "R7" : "R8");
         else         check_bank("R5");
         check("R9", {7'd0, ram_5xxx_en}, {7'd0, m[3][5]});
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule